// File: doc/BRIEF.md
# SIMD Processing-Element Add Array

This block is a row of identical processing elements that all obey one broadcast command stream. Each element owns a small register file and a two's-complement adder whose word size is chosen per command: 8, 16, 32 or 64 bits. The controller broadcasts an opcode, register indices, a 64-bit immediate, a word size and a per-element enable mask. Every enabled element then executes the command on its own registers.

The addend is either a second register or the broadcast immediate. A sum narrower than 64 bits is written back sign-extended to the full register width. Each add also yields four condition flags per element.

For readback, a global-OR network merges the results of all enabled elements into one 64-bit word, and their flag fields into one 4-bit word. Both appear on registered outputs one clock after the add command.

Top module: `simd_add_array`

## Requirements
- R1: An enabled element given opcode 1 (load) writes the full 64-bit `cmd_imm` into register `cmd_dst`.
- R2: Opcode 2 (register add) writes `rf[cmd_srca] + rf[cmd_srcb]` into `rf[cmd_dst]`. The add is computed at the selected width, and the result's top bit is replicated into bits 63 down to that width.
- R3: Opcode 3 (immediate add) adds `cmd_imm`, sign-extended from the selected width, to `rf[cmd_srca]`. Immediate bits at or above the selected width have no effect.
- R4: `cmd_size` encodes the word width as 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits.
- R5: The flag field is packed as negative in bit 3, zero in bit 2, overflow in bit 1 and carry in bit 0. Negative is the sign bit of the sized result. Zero means the sized result is all zeros. Carry is the carry out of the top bit of the selected width.
- R6: Overflow is set only when both operands have the same sign and the sign of the sized result differs from it.
- R7: A disabled element leaves its registers unchanged and puts zeros into both OR reductions. With no element enabled, an add reads back zero result and zero flags.
- R8: `red_valid` is high exactly in the cycle after an add command. In that cycle `red_result` and `red_flags` are the bitwise OR over enabled elements. In every other cycle all three outputs are zero.
- R9: An add issued on the cycle right after another add reads that earlier add's written result.
- R10: While `rst_n` is low, all registers are cleared to zero and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pe_enable | input | 4 | Per-element enable mask for the current command |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 0 no-op, 1 load, 2 register add, 3 immediate add |
| cmd_dst | input | 2 | Destination register index |
| cmd_srca | input | 2 | First source register index |
| cmd_srcb | input | 2 | Second source register index (register add only) |
| cmd_size | input | 2 | Word width code |
| cmd_imm | input | 64 | Load data or immediate addend |
| red_valid | output | 1 | Reduced readback is valid |
| red_result | output | 64 | OR of enabled elements' sign-extended results |
| red_flags | output | 4 | OR of enabled elements' flag fields |

## Verification
Two things happen in the same cycle: the OR readback of one add, and the operand read of the next command from the register that add just wrote. The bench issues chains of dependent adds on consecutive cycles, including adds whose destination is also their source, while it changes the enable mask and word size between commands. A behavioural model of every register updates on each edge and predicts the readback for that edge. The model is compared with all three outputs on every clock, so a stale operand or a readback in the wrong cycle shows up as a mismatch at that exact cycle.

// File: rtl/simd_add_pkg.sv
// Shared types and constants for the SIMD add array.
// Assumes a 64-bit register width and exactly four selectable word sizes.
package simd_add_pkg;
    localparam int WORD_W    = 64;
    localparam int FLAG_W    = 4;
    localparam int NUM_SIZES = 4;
    localparam int BASE_W    = 8;

    typedef enum logic [1:0] {
        OP_NOP    = 2'd0,
        OP_LOAD   = 2'd1,
        OP_ADD_RR = 2'd2,
        OP_ADD_RI = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } size_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } flags_t;

    // Bit index of the sign bit for a word size code.
    function automatic int sign_pos(input size_e sz);
        return (BASE_W << sz) - 1;
    endfunction
endpackage

// File: rtl/pe_adder.sv
// Sized two's-complement adder with condition flags.
// One adder per word size is built in parallel; the size code selects one.
// Assumes WORD_W is BASE_W << (NUM_SIZES-1).
module pe_adder
    import simd_add_pkg::*;
(
    input  size_e              size,
    input  logic [WORD_W-1:0]  opa,
    input  logic [WORD_W-1:0]  opb,
    output logic [WORD_W-1:0]  sum,
    output flags_t             flags
);
    logic [WORD_W-1:0] sum_k   [NUM_SIZES];
    flags_t            flags_k [NUM_SIZES];

    for (genvar k = 0; k < NUM_SIZES; k++) begin : g_width
        localparam int W = BASE_W << k;
        logic [W:0] raw;
        // Width-W add with carry out in bit W.
        assign raw = {1'b0, opa[W-1:0]} + {1'b0, opb[W-1:0]};
        if (W < WORD_W) begin : g_ext
            assign sum_k[k] = {{(WORD_W-W){raw[W-1]}}, raw[W-1:0]};
        end else begin : g_full
            assign sum_k[k] = raw[W-1:0];
        end
        assign flags_k[k].neg   = raw[W-1];
        assign flags_k[k].zero  = (raw[W-1:0] == '0);
        assign flags_k[k].ovf   = (opa[W-1] == opb[W-1]) && (raw[W-1] != opa[W-1]);
        assign flags_k[k].carry = raw[W];
    end

    // Pick the adder matching the broadcast size code.
    always_comb begin
        sum   = sum_k[size];
        flags = flags_k[size];
    end
endmodule

// File: rtl/or_reduce.sv
// Bitwise OR of N words of width W.
// Purely combinational; callers zero the words that must not contribute.
module or_reduce #(
    parameter int N = 4,
    parameter int W = 64
) (
    input  logic [N-1:0][W-1:0] din,
    output logic [W-1:0]        dout
);
    // Accumulate the OR across all inputs.
    always_comb begin
        dout = '0;
        for (int i = 0; i < N; i++) begin
            dout = dout | din[i];
        end
    end
endmodule

// File: rtl/pe_lane.sv
// One processing element: register file, operand select, adder, and output gating.
// Assumes commands are broadcast and applied only when lane_en is high.
// Its contribution to the reductions is zero unless it is enabled and the command is an add.
module pe_lane
    import simd_add_pkg::*;
#(
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lane_en,
    input  logic              cmd_valid,
    input  op_e               op,
    input  logic [IDX_W-1:0]  dst,
    input  logic [IDX_W-1:0]  srca,
    input  logic [IDX_W-1:0]  srcb,
    input  size_e             size,
    input  logic [WORD_W-1:0] imm,
    output logic [WORD_W-1:0] lane_res,
    output logic [FLAG_W-1:0] lane_flags
);
    logic [NUM_REGS-1:0][WORD_W-1:0] rf;
    logic [WORD_W-1:0] opa, opb, sum;
    flags_t            flg;
    logic              is_add, do_cmd;

    assign is_add = (op == OP_ADD_RR) || (op == OP_ADD_RI);
    assign do_cmd = cmd_valid && lane_en;

    // Operand selection: second register or broadcast immediate.
    always_comb begin
        opa = rf[srca];
        opb = (op == OP_ADD_RI) ? imm : rf[srcb];
    end

    pe_adder u_adder (
        .size  (size),
        .opa   (opa),
        .opb   (opb),
        .sum   (sum),
        .flags (flg)
    );

    // Register file write: load or add writeback.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf <= '0;
        end else if (do_cmd) begin
            if (op == OP_LOAD) begin
                rf[dst] <= imm;
            end else if (is_add) begin
                rf[dst] <= sum;
            end
        end
    end

    // Gate the contribution to the reductions.
    always_comb begin
        lane_res   = (do_cmd && is_add) ? sum : '0;
        lane_flags = (do_cmd && is_add) ? flg : '0;
    end

    // R7: a disabled lane keeps its registers.
    a_r7_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !lane_en |=> $stable(rf));

    // R2: the written word is sign-extended from the selected width.
    always_ff @(posedge clk) begin
        if (rst_n && do_cmd && is_add) begin
            a_r2_sign_extended: assert (sum == WORD_W'($signed(sum << (WORD_W-1-sign_pos(size))) >>> (WORD_W-1-sign_pos(size))));
        end
    end

    // R6: operands of opposite sign never overflow.
    always_ff @(posedge clk) begin
        if (rst_n && do_cmd && is_add && (opa[sign_pos(size)] != opb[sign_pos(size)])) begin
            a_r6_no_overflow: assert (!flg.ovf);
        end
    end
endmodule

// File: rtl/simd_add_array.sv
// SIMD add array top: NUM_PE lanes driven by one broadcast command, plus
// OR-reduction of the lane results and flags into registered readback outputs.
// Assumes synchronous active-low reset; readback is valid one clock after an add.
module simd_add_array
    import simd_add_pkg::*;
#(
    parameter int NUM_PE   = 4,
    parameter int NUM_REGS = 4,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PE-1:0] pe_enable,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_dst,
    input  logic [IDX_W-1:0]  cmd_srca,
    input  logic [IDX_W-1:0]  cmd_srcb,
    input  logic [1:0]        cmd_size,
    input  logic [WORD_W-1:0] cmd_imm,
    output logic              red_valid,
    output logic [WORD_W-1:0] red_result,
    output logic [FLAG_W-1:0] red_flags
);
    op_e   op;
    size_e size;
    logic  add_cmd;
    logic [NUM_PE-1:0][WORD_W-1:0] lane_res;
    logic [NUM_PE-1:0][FLAG_W-1:0] lane_flags;
    logic [WORD_W-1:0] or_res;
    logic [FLAG_W-1:0] or_flags;

    assign op      = op_e'(cmd_op);
    assign size    = size_e'(cmd_size);
    assign add_cmd = cmd_valid && ((op == OP_ADD_RR) || (op == OP_ADD_RI));

    for (genvar p = 0; p < NUM_PE; p++) begin : g_pe
        pe_lane #(.NUM_REGS(NUM_REGS)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .lane_en    (pe_enable[p]),
            .cmd_valid  (cmd_valid),
            .op         (op),
            .dst        (cmd_dst),
            .srca       (cmd_srca),
            .srcb       (cmd_srcb),
            .size       (size),
            .imm        (cmd_imm),
            .lane_res   (lane_res[p]),
            .lane_flags (lane_flags[p])
        );
    end

    or_reduce #(.N(NUM_PE), .W(WORD_W)) u_or_res (
        .din  (lane_res),
        .dout (or_res)
    );

    or_reduce #(.N(NUM_PE), .W(FLAG_W)) u_or_flags (
        .din  (lane_flags),
        .dout (or_flags)
    );

    // Register the reduced readback; zero when no add was issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            red_valid  <= 1'b0;
            red_result <= '0;
            red_flags  <= '0;
        end else begin
            red_valid  <= add_cmd;
            red_result <= add_cmd ? or_res : '0;
            red_flags  <= add_cmd ? or_flags : '0;
        end
    end

    // R8: readback valid follows every add by one cycle.
    a_r8_valid_after_add: assert property (@(posedge clk) disable iff (!rst_n)
        add_cmd |=> red_valid);

    // R8: no add means quiet outputs next cycle.
    a_r8_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !add_cmd |=> (!red_valid && red_result == '0 && red_flags == '0));

    // R7: an add with every lane disabled reads back zero.
    a_r7_none_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (add_cmd && pe_enable == '0) |=> (red_result == '0 && red_flags == '0));

    // R10: reset clears the readback.
    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!red_valid && red_result == '0 && red_flags == '0));
endmodule

// File: tb/simd_add_array_tb_top.sv
// Self-checking bench: behavioural model of every register, compared each clock.
module simd_add_array_tb_top;
    localparam int NP = 4;
    localparam int NR = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pe_enable = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [1:0]    cmd_dst = '0, cmd_srca = '0, cmd_srcb = '0;
    logic [1:0]    cmd_size = '0;
    logic [63:0]   cmd_imm = '0;
    logic          red_valid;
    logic [63:0]   red_result;
    logic [3:0]    red_flags;

    int total = 0;
    int bad = 0;

    logic [63:0] mrf [NP][NR];
    logic        exp_valid = 1'b0;
    logic [63:0] exp_res = '0;
    logic [3:0]  exp_flags = '0;
    string       exp_req = "R10";

    always #2.5 clk = ~clk;

    simd_add_array #(.NUM_PE(NP), .NUM_REGS(NR)) dut_i (
        .clk(clk), .rst_n(rst_n), .pe_enable(pe_enable), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_srca(cmd_srca), .cmd_srcb(cmd_srcb),
        .cmd_size(cmd_size), .cmd_imm(cmd_imm),
        .red_valid(red_valid), .red_result(red_result), .red_flags(red_flags)
    );

    // Reference add: width w, flags {N,Z,V,C}.
    function automatic void madd(input logic [63:0] a, input logic [63:0] b, input int w,
                                 output logic [63:0] r, output logic [3:0] f);
        logic [64:0] mask, s;
        logic [63:0] am, bm, low;
        logic sa, sb, sr;
        mask = (65'd1 << w) - 65'd1;
        am = a & mask[63:0];
        bm = b & mask[63:0];
        s  = {1'b0, am} + {1'b0, bm};
        low = s[63:0] & mask[63:0];
        sa = am[w-1]; sb = bm[w-1]; sr = s[w-1];
        r = sr ? (low | ~mask[63:0]) : low;
        f = {sr, (low == 64'd0), (sa == sb) && (sr != sa), s[w]};
    endfunction

    task automatic compare();
        total++;
        if (red_valid !== exp_valid || red_result !== exp_res || red_flags !== exp_flags) begin
            bad++;
            $display("FAIL %s: got valid=%0b result=%h flags=%b, expected valid=%0b result=%h flags=%b",
                     exp_req, red_valid, red_result, red_flags, exp_valid, exp_res, exp_flags);
        end
    endtask

    // One clock: check the readback of the previous edge, then drive and model the next command.
    task automatic step(input logic v, input logic [1:0] op, input int d, input int sa, input int sb,
                        input logic [1:0] sz, input logic [63:0] imm, input logic [NP-1:0] en,
                        input string req);
        logic [63:0] r, nres;
        logic [3:0]  f, nflg;
        logic [63:0] upd [NP];
        logic        isadd;
        @(negedge clk);
        compare();
        cmd_valid = v; cmd_op = op; cmd_dst = 2'(d); cmd_srca = 2'(sa); cmd_srcb = 2'(sb);
        cmd_size = sz; cmd_imm = imm; pe_enable = en;
        isadd = v && (op == 2'd2 || op == 2'd3) && rst_n;
        nres = '0; nflg = '0;
        for (int p = 0; p < NP; p++) begin
            upd[p] = mrf[p][d];
            if (v && en[p] && rst_n) begin
                if (op == 2'd1) upd[p] = imm;
                else if (op != 2'd0) begin
                    madd(mrf[p][sa], (op == 2'd3) ? imm : mrf[p][sb], 8 << sz, r, f);
                    upd[p] = r;
                    nres |= r; nflg |= f;
                end
            end
        end
        for (int p = 0; p < NP; p++) mrf[p][d] = upd[p];
        exp_valid = isadd;
        exp_res   = isadd ? nres : '0;
        exp_flags = isadd ? nflg : '0;
        exp_req   = req;
    endtask

    task automatic idle(input string req);
        step(1'b0, 2'd0, 0, 0, 0, 2'd0, 64'd0, '0, req);
    endtask

    initial begin
        for (int p = 0; p < NP; p++) for (int i = 0; i < NR; i++) mrf[p][i] = '0;
        // R10: outputs zero during reset
        idle("R10"); idle("R10"); idle("R10");
        rst_n = 1'b1;
        // R10: registers read as zero after reset
        step(1'b1, 2'd2, 0, 1, 2, 2'd3, 64'd0, 4'hF, "R10");
        // R1: broadcast loads
        step(1'b1, 2'd1, 1, 0, 0, 2'd0, 64'd1, 4'hF, "R1");
        step(1'b1, 2'd1, 2, 0, 0, 2'd0, '1, 4'hF, "R1");
        step(1'b1, 2'd1, 3, 0, 0, 2'd0, -64'sd81, 4'hF, "R1");
        step(1'b1, 2'd3, 0, 3, 0, 2'd3, 64'd0, 4'hF, "R1");
        // R2, R4, R5: register adds at every width
        for (int s = 0; s < 4; s++) begin
            step(1'b1, 2'd2, 0, 1, 1, 2'(s), 64'd0, 4'hF, "R2");
            step(1'b1, 2'd2, 0, 1, 2, 2'(s), 64'd0, 4'hF, "R5");
            step(1'b1, 2'd2, 0, 2, 2, 2'(s), 64'd0, 4'hF, "R5");
            step(1'b1, 2'd2, 0, 1, 3, 2'(s), 64'd0, 4'hF, "R4");
        end
        // R3: immediate adds, including junk above the selected width
        for (int s = 0; s < 4; s++) begin
            step(1'b1, 2'd3, 0, 1, 0, 2'(s), 64'd1, 4'hF, "R3");
            step(1'b1, 2'd3, 0, 1, 0, 2'(s), '1, 4'hF, "R3");
            step(1'b1, 2'd3, 0, 2, 0, 2'(s), '1, 4'hF, "R3");
            step(1'b1, 2'd3, 0, 1, 0, 2'(s), -64'sd81, 4'hF, "R3");
            step(1'b1, 2'd3, 0, 2, 0, 2'(s), 64'hA5A5_5A5A_C3C3_0001, 4'hF, "R3");
        end
        // R6: signed overflow at each width
        step(1'b1, 2'd1, 1, 0, 0, 2'd0, 64'h7FFF_FFFF_FFFF_FFFF, 4'hF, "R1");
        for (int s = 0; s < 4; s++) begin
            step(1'b1, 2'd3, 0, 1, 0, 2'(s), 64'd1, 4'hF, "R6");
            step(1'b1, 2'd3, 0, 1, 0, 2'(s), 64'h8000_0000_8000_8080, 4'hF, "R6");
        end
        step(1'b1, 2'd1, 1, 0, 0, 2'd0, 64'h8000_0000_8000_8080, 4'hF, "R1");
        for (int s = 0; s < 4; s++) step(1'b1, 2'd2, 0, 1, 1, 2'(s), 64'd0, 4'hF, "R6");
        // R7, R8: different data per lane through enable masks
        step(1'b1, 2'd1, 2, 0, 0, 2'd0, 64'h10, 4'b0101, "R7");
        step(1'b1, 2'd1, 2, 0, 0, 2'd0, 64'h200, 4'b1010, "R7");
        step(1'b1, 2'd3, 3, 2, 0, 2'd3, 64'd0, 4'b0001, "R8");
        step(1'b1, 2'd3, 3, 2, 0, 2'd3, 64'd0, 4'b0010, "R8");
        step(1'b1, 2'd3, 3, 2, 0, 2'd3, 64'd0, 4'b1111, "R8");
        step(1'b1, 2'd1, 2, 0, 0, 2'd0, 64'hDEAD, 4'b0011, "R7");
        step(1'b1, 2'd3, 0, 2, 0, 2'd3, 64'd0, 4'b1100, "R7");
        step(1'b1, 2'd2, 2, 2, 2, 2'd0, 64'd0, 4'b0000, "R7");
        step(1'b1, 2'd3, 0, 2, 0, 2'd3, 64'd0, 4'b1111, "R7");
        idle("R8");
        step(1'b1, 2'd1, 0, 0, 0, 2'd0, 64'h55, 4'hF, "R8");
        idle("R8");
        // R9: dependent adds on consecutive cycles, size and mask changing
        step(1'b1, 2'd3, 0, 2, 0, 2'd1, 64'd5, 4'hF, "R9");
        step(1'b1, 2'd3, 0, 0, 0, 2'd1, 64'd5, 4'b0110, "R9");
        step(1'b1, 2'd2, 1, 0, 0, 2'd0, 64'd0, 4'hF, "R9");
        step(1'b1, 2'd2, 1, 1, 0, 2'd2, 64'd0, 4'b1001, "R9");
        step(1'b1, 2'd3, 1, 1, 0, 2'd3, '1, 4'hF, "R9");
        idle("R9");
        idle("R8");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        bad++;
        $display("FAIL watchdog: run did not complete, got timeout, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule